// File: doc/BRIEF.md
# Timed Operation Sequencer for a Configurable Array

This block sits between a serial command decoder and the fabric of a reconfigurable array. The decoder presents one request at a time: a configuration write, a debug register read, or a switch of the fabric clock selection. Each request carries a 32-bit cycle budget, an address and a data word. The controller runs the operation for that many cycles and then goes back to its idle condition, with `ready` high.

While an operation is running, the matching fabric strobe stays high. For a read, the value on the fabric read bus during the last busy cycle is stored, and the front end can sample it once `ready` returns. For a clock switch, a registered select bit takes its new value on the cycle the switch finishes. No other operation can begin until the running one ends, and this includes the clock switch.

The cycle count is held in a down-counter that is loaded with the budget minus one. A budget of zero is handled the same way as a budget of one, so the counter can never wrap to all ones.

Top module: `gctl_top`

## Requirements
- R1: A synchronous active-high `rst` sets `ready` to 1, clears `fab_wr`, `fab_rd`, `clk_sel` and `rdata_q` to 0, and abandons any operation that is running.
- R2: A request is accepted only on a cycle where `req_valid` and `ready` are both 1. The opcodes are 2'b01 write, 2'b10 read and 2'b11 clock switch. Opcode 2'b00, or `req_valid` low, leaves `ready` at 1 and changes no output.
- R3: After a request with budget D ≥ 1 is accepted, `ready` is 0 for exactly D consecutive cycles, starting in the cycle after acceptance, and then returns to 1.
- R4: A request with budget 0 keeps `ready` at 0 for exactly one cycle. The internal counter never wraps below zero.
- R5: For a write, `fab_wr` is 1 in every busy cycle and in no other cycle. During those cycles `fab_addr` and `fab_wdata` show the accepted `req_addr` and `req_wdata`.
- R6: For a read, `fab_rd` is 1 in every busy cycle and in no other cycle. `rdata_q` takes the value of `fab_rdata` from the last busy cycle and keeps it until the next read completes.
- R7: A clock switch raises neither strobe. `clk_sel` keeps its old value while the switch is busy. It takes the accepted `req_wdata[0]` in the same cycle that `ready` returns to 1.
- R8: Requests that arrive while `ready` is 0 are ignored. This covers a write presented one cycle after a clock switch: it raises no strobe, does not change the fabric address, and does not lengthen the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Opcode: 01 write, 10 read, 11 clock switch, 00 none |
| req_delay | input | DLY_W (32) | Busy-cycle budget for the operation |
| req_addr | input | ADDR_W (16) | Fabric address for read or write |
| req_wdata | input | DATA_W (32) | Write data; bit 0 is the clock-select target |
| fab_rdata | input | DATA_W (32) | Read data from the fabric |
| ready | output | 1 | Idle and able to accept a request |
| fab_rd | output | 1 | Fabric read strobe |
| fab_wr | output | 1 | Fabric write strobe |
| fab_addr | output | ADDR_W (16) | Latched fabric address |
| fab_wdata | output | DATA_W (32) | Latched fabric write data |
| clk_sel | output | 1 | Registered clock-select bit |
| rdata_q | output | DATA_W (32) | Captured read result |

## Verification
Budgets of 0, 1, a small value and a few hundred are run through all three opcodes. Comparing the measured busy length across these budgets tells the zero special case apart from an ordinary load and from an off-by-one in the counter. During reads, `fab_rdata` changes every cycle, so a capture taken on any cycle other than the last gives a visibly wrong word. Requests with opcode none, with `req_valid` low, during a read, and one cycle after a clock switch each show whether acceptance is gated by `ready` alone. A reset issued in the middle of a write shows that a running operation is abandoned.

// File: rtl/gctl_pkg.sv
package gctl_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_WR   = 2'b01,
        OP_RD   = 2'b10,
        OP_SW   = 2'b11
    } gc_op_e;

    typedef enum logic [1:0] {
        GC_IDLE = 2'b00,
        GC_WR   = 2'b01,
        GC_RD   = 2'b10,
        GC_SW   = 2'b11
    } gc_state_e;

    // Maps a request opcode onto the busy state it starts.
    function automatic gc_state_e op_to_state(input logic [1:0] op);
        case (op)
            2'b01:   return GC_WR;
            2'b10:   return GC_RD;
            2'b11:   return GC_SW;
            default: return GC_IDLE;
        endcase
    endfunction

    // An opcode of none never starts an operation.
    function automatic logic op_is_real(input logic [1:0] op);
        return op != 2'b00;
    endfunction

endpackage

// File: rtl/gctl_cycle_counter.sv
module gctl_cycle_counter #(
    parameter int DLY_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] delay,
    output logic [DLY_W-1:0] cnt,
    output logic             cnt_zero
);
    localparam logic [DLY_W-1:0] ONE  = DLY_W'(1);
    localparam logic [DLY_W-1:0] ZERO = '0;

    logic [DLY_W-1:0] reload;

    // A zero budget loads zero, the same as a budget of one, so the load never wraps.
    always_comb begin
        if (delay == ZERO) reload = ZERO;
        else               reload = delay - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)              cnt <= ZERO;
        else if (load)        cnt <= reload;
        else if (cnt != ZERO) cnt <= cnt - ONE;
    end

    assign cnt_zero = (cnt == ZERO);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != ZERO) |=> (cnt == $past(cnt) - ONE));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == ZERO) |=> (cnt == ZERO));

endmodule

// File: rtl/gctl_op_fsm.sv
module gctl_op_fsm
    import gctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic [1:0] req_op,
    input  logic      cnt_zero,
    output gc_state_e state,
    output logic      accept,
    output logic      done
);
    gc_state_e state_nx;

    assign accept = req_valid && (state == GC_IDLE) && op_is_real(req_op);
    assign done   = (state != GC_IDLE) && cnt_zero;

    always_comb begin
        state_nx = state;
        if (accept)    state_nx = op_to_state(req_op);
        else if (done) state_nx = GC_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= GC_IDLE;
        else     state <= state_nx;
    end

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != GC_IDLE && !cnt_zero) |=> (state == $past(state)));

    // R3
    finish_chk: assert property (@(posedge clk) disable iff (rst)
        (state != GC_IDLE && cnt_zero) |=> (state == GC_IDLE));

endmodule

// File: rtl/gctl_fabric_port.sv
module gctl_fabric_port
    import gctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  gc_state_e         state,
    input  logic              accept,
    input  logic              done,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] fab_rdata,
    output logic              fab_rd,
    output logic              fab_wr,
    output logic [ADDR_W-1:0] fab_addr,
    output logic [DATA_W-1:0] fab_wdata,
    output logic              clk_sel,
    output logic [DATA_W-1:0] rdata_q
);
    logic clk_target;

    // The strobes are registers of their own, set on acceptance and cleared on completion.
    always_ff @(posedge clk) begin
        if (rst) begin
            fab_wr <= 1'b0;
            fab_rd <= 1'b0;
        end else if (accept) begin
            fab_wr <= (req_op == OP_WR);
            fab_rd <= (req_op == OP_RD);
        end else if (done) begin
            fab_wr <= 1'b0;
            fab_rd <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fab_addr   <= '0;
            fab_wdata  <= '0;
            clk_target <= 1'b0;
        end else if (accept) begin
            if (req_op != OP_SW) begin
                fab_addr  <= req_addr;
                fab_wdata <= req_wdata;
            end else begin
                clk_target <= req_wdata[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        clk_sel <= 1'b0;
        else if (done && state == GC_SW) clk_sel <= clk_target;
    end

    always_ff @(posedge clk) begin
        if (rst)                        rdata_q <= '0;
        else if (done && state == GC_RD) rdata_q <= fab_rdata;
    end

    // R5
    wr_in_state_chk: assert property (@(posedge clk) disable iff (rst)
        fab_wr |-> (state == GC_WR));

    // R6
    rd_in_state_chk: assert property (@(posedge clk) disable iff (rst)
        fab_rd |-> (state == GC_RD));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fab_wr, fab_rd}));

endmodule

// File: rtl/gctl_top.sv
module gctl_top
    import gctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DLY_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [DLY_W-1:0]  req_delay,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] fab_rdata,
    output logic              ready,
    output logic              fab_rd,
    output logic              fab_wr,
    output logic [ADDR_W-1:0] fab_addr,
    output logic [DATA_W-1:0] fab_wdata,
    output logic              clk_sel,
    output logic [DATA_W-1:0] rdata_q
);
    gc_state_e        state;
    logic             accept;
    logic             done;
    logic             cnt_zero;
    logic [DLY_W-1:0] cnt;

    gctl_op_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .cnt_zero  (cnt_zero),
        .state     (state),
        .accept    (accept),
        .done      (done)
    );

    gctl_cycle_counter #(.DLY_W(DLY_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .delay    (req_delay),
        .cnt      (cnt),
        .cnt_zero (cnt_zero)
    );

    gctl_fabric_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .accept    (accept),
        .done      (done),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .fab_rdata (fab_rdata),
        .fab_rd    (fab_rd),
        .fab_wr    (fab_wr),
        .fab_addr  (fab_addr),
        .fab_wdata (fab_wdata),
        .clk_sel   (clk_sel),
        .rdata_q   (rdata_q)
    );

    assign ready = (state == GC_IDLE);

    // R7
    switch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == GC_SW) |-> (!fab_wr && !fab_rd));

    // R7
    sel_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (state == GC_SW && cnt != '0) |=> $stable(clk_sel));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!fab_wr && !fab_rd));

endmodule

// File: tb/tb_gctl_top.sv
module tb_gctl_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int DLY_W  = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'b00;
    logic [DLY_W-1:0]  req_delay = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] fab_rdata;
    logic              ready, fab_rd, fab_wr, clk_sel;
    logic [ADDR_W-1:0] fab_addr;
    logic [DATA_W-1:0] fab_wdata, rdata_q;

    int    n_chk = 0;
    int    n_bad = 0;
    int    tb_cyc = 0;
    logic [DATA_W-1:0] last_rd;
    bit    done_flag = 0;

    always #10 clk = ~clk;
    always_ff @(posedge clk) tb_cyc <= tb_cyc + 1;

    // Read data changes every cycle, so the capture cycle is visible.
    assign fab_rdata = {fab_addr, tb_cyc[15:0]};

    gctl_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_delay(req_delay), .req_addr(req_addr), .req_wdata(req_wdata),
        .fab_rdata(fab_rdata), .ready(ready), .fab_rd(fab_rd), .fab_wr(fab_wr),
        .fab_addr(fab_addr), .fab_wdata(fab_wdata), .clk_sel(clk_sel),
        .rdata_q(rdata_q)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issues a request on one cycle, then counts busy cycles and strobe behaviour.
    task automatic run_op(input logic [1:0] op, input logic [31:0] dly,
                          input logic [15:0] addr, input logic [31:0] wd,
                          input int exp_busy, input string req,
                          input bit exp_wr, input bit exp_rd);
        int busy = 0;
        int bad_wr = 0;
        int bad_rd = 0;
        int bad_addr = 0;
        @(negedge clk);
        req_op = op; req_delay = dly; req_addr = addr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!ready && busy < 5000) begin
            if (fab_wr !== exp_wr) bad_wr++;
            if (fab_rd !== exp_rd) bad_rd++;
            if ((exp_wr || exp_rd) && fab_addr !== addr) bad_addr++;
            if (exp_rd) last_rd = {fab_addr, tb_cyc[15:0]};
            busy++;
            @(negedge clk);
        end
        chk(req, "busy cycles", 64'(busy), 64'(exp_busy));
        chk(req, "wr strobe mismatch cycles", 64'(bad_wr), 64'd0);
        chk(req, "rd strobe mismatch cycles", 64'(bad_rd), 64'd0);
        chk(req, "addr mismatch cycles", 64'(bad_addr), 64'd0);
        chk(req, "strobes low after", {62'd0, fab_wr, fab_rd}, 64'd0);
    endtask

    task automatic t_reset;
        chk("R1", "ready", 64'(ready), 64'd1);
        chk("R1", "strobes", {62'd0, fab_wr, fab_rd}, 64'd0);
        chk("R1", "clk_sel", 64'(clk_sel), 64'd0);
        chk("R1", "rdata_q", 64'(rdata_q), 64'd0);
    endtask

    task automatic t_write;
        run_op(2'b01, 32'd5, 16'h1234, 32'hCAFE0001, 5, "R5", 1'b1, 1'b0);
        chk("R5", "fab_wdata", 64'(fab_wdata), 64'hCAFE0001);
        run_op(2'b01, 32'd1, 16'h0042, 32'h00000077, 1, "R3", 1'b1, 1'b0);
        run_op(2'b01, 32'd300, 16'h0ABC, 32'h5, 300, "R3", 1'b1, 1'b0);
    endtask

    task automatic t_zero;
        run_op(2'b01, 32'd0, 16'h0101, 32'h9, 1, "R4", 1'b1, 1'b0);
        run_op(2'b10, 32'd0, 16'h0202, 32'h0, 1, "R4", 1'b0, 1'b1);
        chk("R4", "rdata_q zero-budget read", 64'(rdata_q), 64'(last_rd));
    endtask

    task automatic t_read;
        logic [31:0] cap;
        run_op(2'b10, 32'd4, 16'hBEEF, 32'h0, 4, "R6", 1'b0, 1'b1);
        cap = last_rd;
        chk("R6", "rdata_q last busy cycle", 64'(rdata_q), 64'(cap));
        repeat (3) @(negedge clk);
        chk("R6", "rdata_q held", 64'(rdata_q), 64'(cap));
        run_op(2'b01, 32'd2, 16'h0001, 32'h1, 2, "R6", 1'b1, 1'b0);
        chk("R6", "rdata_q unchanged by write", 64'(rdata_q), 64'(cap));
    endtask

    task automatic t_switch;
        int busy = 0;
        int sel_bad = 0;
        @(negedge clk);
        req_op = 2'b11; req_delay = 32'd3; req_wdata = 32'h1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!ready && busy < 100) begin
            if (clk_sel !== 1'b0) sel_bad++;
            if (fab_wr || fab_rd) sel_bad++;
            busy++;
            @(negedge clk);
        end
        chk("R7", "switch busy cycles", 64'(busy), 64'd3);
        chk("R7", "sel or strobe during switch", 64'(sel_bad), 64'd0);
        chk("R7", "clk_sel after switch", 64'(clk_sel), 64'd1);
    endtask

    task automatic t_switch_then_write;
        int busy = 0;
        int wr_seen = 0;
        logic [15:0] addr_before;
        addr_before = fab_addr;
        @(negedge clk);
        req_op = 2'b11; req_delay = 32'd3; req_wdata = 32'h0; req_valid = 1'b1;
        @(negedge clk);
        // One cycle later, while busy, a write is presented and held.
        req_op = 2'b01; req_delay = 32'd9; req_addr = 16'h7777; req_wdata = 32'hDEAD;
        while (!ready && busy < 100) begin
            if (fab_wr) wr_seen++;
            busy++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R8", "busy not lengthened", 64'(busy), 64'd3);
        chk("R8", "write strobe during switch", 64'(wr_seen), 64'd0);
        chk("R8", "fab_addr unchanged", 64'(fab_addr), 64'(addr_before));
        chk("R7", "clk_sel back to 0", 64'(clk_sel), 64'd0);
    endtask

    task automatic t_read_blocks_write;
        int busy = 0;
        int wr_seen = 0;
        @(negedge clk);
        req_op = 2'b10; req_delay = 32'd4; req_addr = 16'h3333; req_valid = 1'b1;
        @(negedge clk);
        req_op = 2'b01; req_addr = 16'h4444;
        while (!ready && busy < 100) begin
            if (fab_wr) wr_seen++;
            if (fab_addr !== 16'h3333) wr_seen++;
            busy++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R8", "read busy with write held", 64'(busy), 64'd4);
        chk("R8", "write effect during read", 64'(wr_seen), 64'd0);
    endtask

    task automatic t_ignored;
        logic [15:0] a0;
        a0 = fab_addr;
        @(negedge clk);
        req_op = 2'b00; req_delay = 32'd5; req_addr = 16'h5555; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "ready after none opcode", 64'(ready), 64'd1);
        chk("R2", "addr after none opcode", 64'(fab_addr), 64'(a0));
        req_op = 2'b01; req_addr = 16'h6666;
        @(negedge clk);
        chk("R2", "ready with valid low", 64'(ready), 64'd1);
        chk("R2", "strobe with valid low", 64'(fab_wr), 64'd0);
        chk("R2", "addr with valid low", 64'(fab_addr), 64'(a0));
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        req_op = 2'b01; req_delay = 32'd50; req_addr = 16'h0F0F; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "busy before reset", 64'(ready), 64'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "ready after mid reset", 64'(ready), 64'd1);
        chk("R1", "wr after mid reset", 64'(fab_wr), 64'd0);
        @(negedge clk);
        chk("R1", "stays idle", 64'(ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_zero();
        t_read();
        t_switch();
        t_switch_then_write();
        t_read_blocks_write();
        t_ignored();
        t_reset_mid();
        done_flag = 1;
    end

    initial begin
        int w = 0;
        while (!done_flag && w < 100000) begin
            @(posedge clk);
            w++;
        end
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule